// File: doc/BRIEF.md
# Throttle State Input Filter

This block sits between the links that deliver a 4-bit throttle state from each front-end module and the logic that decides whether triggers may be sent. For every channel it keeps a filtered state. A critical code must arrive on several consecutive samples before that state takes it, while the benign codes are taken at once. For each channel the block also gives a five-bit one-hot view of the filtered state and three sticky history flags for the critical states. Across all channels it forms one combined one-hot throttle state.

Each channel can be switched off in two ways: an enable mask, or an ignore mask used when a module misbehaves. A channel that is switched off reads as ready and has no effect on the combined state. A resync strobe forces the combined state to busy until every active channel has sent a ready code again. A clear strobe wipes the history flags and restarts the repeat counting.

Top module: `tts_filter_top`

## Requirements
- R1: Ready (0x8), busy (0x4) and overflow warning (0x1) codes on an active channel appear on that channel's `filt_code_o` after the clock edge that samples them.
- R2: Critical codes are 0x2 (out of sync), 0xC (error), 0x0 and 0xF (disconnected) and every undefined code (counted as error). One of them appears on `filt_code_o` only at the edge that samples the same code for the RPT-th consecutive time (RPT = 4). Until then the previous filtered value stays.
- R3: Any different code breaks a run of a critical code, so counting starts over at the next sample of that code.
- R4: `state_oh_o[5*ch +: 5]` is one-hot with bit 4 = disconnected, bit 3 = error, bit 2 = out of sync, bit 1 = busy, bit 0 = overflow warning. Ready is all zero, and undefined codes set bit 3.
- R5: `hist_o[3*ch +: 3]` holds bit 2 = has been disconnected, bit 1 = has been in error, bit 0 = has been out of sync. A flag sets at the same edge the filtered state enters that state, and it stays set.
- R6: A clear strobe sampled at an edge zeroes all history flags and all run counts. A critical code therefore needs RPT further consecutive samples after the clear edge.
- R7: A channel with `chan_en_i` low or `chan_ign_i` high reads 0x8 on `filt_code_o` and zero on `state_oh_o` in the same cycle. It is left out of the combined state, and its history flags do not change except by clear.
- R8: `comb_oh_o` is the highest-priority bit (order as in R4) of all active channels' one-hot states. It is zero when no such bit is set.
- R9: From the edge that samples `resync_i`, the busy bit joins the combined state until released. A higher-priority channel state still wins.
- R10: The resync hold ends at the first later edge by which every active channel has been sampled sending a raw 0x8 since the resync. A channel that is inactive at that edge counts as done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_code_i | input | 4*NCH | Raw 4-bit state code per channel, channel ch at [4*ch +: 4] |
| chan_en_i | input | NCH | Channel enable mask |
| chan_ign_i | input | NCH | Channel ignore mask |
| resync_i | input | 1 | Resync strobe |
| clear_i | input | 1 | History and run-count clear strobe |
| filt_code_o | output | 4*NCH | Filtered code per channel |
| state_oh_o | output | 5*NCH | One-hot filtered state per channel |
| hist_o | output | 3*NCH | Sticky critical-state flags per channel |
| comb_oh_o | output | 5 | Combined one-hot throttle state |

## Verification
The per-channel filtered code, one-hot state and history flags change at the edge that samples the raw code, so they are due one edge after the code is applied. A critical code is due at the edge of its fourth consecutive sample. The mask gating and the combined state are combinational from the registered channel states and the masks. Because of that they follow a mask change in the same cycle and a channel change at the same edge, while the resync busy bit shows from the edge that samples the strobe. The bench drives inputs just after the falling edge, steps its own model at the rising edge, and compares every output at the following falling edge. Directed checks sample the outputs right after a mask change, before any edge.

// File: rtl/tts_filt_pkg.sv
package tts_filt_pkg;
  localparam int CODE_W = 4;
  localparam int OH_W   = 5;
  localparam int HIST_W = 3;

  localparam logic [CODE_W-1:0] CODE_READY = 4'h8;
  localparam logic [CODE_W-1:0] CODE_BUSY  = 4'h4;
  localparam logic [CODE_W-1:0] CODE_OFW   = 4'h1;
  localparam logic [CODE_W-1:0] CODE_OOS   = 4'h2;
  localparam logic [CODE_W-1:0] CODE_ERR   = 4'hC;
  localparam logic [CODE_W-1:0] CODE_DIS_A = 4'h0;
  localparam logic [CODE_W-1:0] CODE_DIS_B = 4'hF;

  // one-hot bit positions, highest priority first
  localparam int OH_DIS  = 4;
  localparam int OH_ERR  = 3;
  localparam int OH_OOS  = 2;
  localparam int OH_BUSY = 1;
  localparam int OH_OFW  = 0;

  function automatic logic [OH_W-1:0] code_onehot(input logic [CODE_W-1:0] c);
    logic [OH_W-1:0] v;
    v = '0;
    unique case (c)
      CODE_READY:             v = '0;
      CODE_BUSY:              v[OH_BUSY] = 1'b1;
      CODE_OFW:               v[OH_OFW]  = 1'b1;
      CODE_OOS:               v[OH_OOS]  = 1'b1;
      CODE_DIS_A, CODE_DIS_B: v[OH_DIS]  = 1'b1;
      default:                v[OH_ERR]  = 1'b1;
    endcase
    return v;
  endfunction

  function automatic logic [HIST_W-1:0] code_crit_bits(input logic [CODE_W-1:0] c);
    logic [OH_W-1:0] v;
    v = code_onehot(c);
    return {v[OH_DIS], v[OH_ERR], v[OH_OOS]};
  endfunction

  function automatic logic code_is_crit(input logic [CODE_W-1:0] c);
    return |code_crit_bits(c);
  endfunction

  function automatic logic [OH_W-1:0] prio_pick(input logic [OH_W-1:0] v);
    logic [OH_W-1:0] r;
    r = '0;
    for (int b = OH_W - 1; b >= 0; b--) begin
      if (v[b] && r == '0) r[b] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/tts_chan_filter.sv
module tts_chan_filter
  import tts_filt_pkg::*;
#(
  parameter int RPT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] raw_i,
  input  logic              active_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] filt_o,
  output logic [OH_W-1:0]   onehot_o,
  output logic [HIST_W-1:0] hist_o,
  output logic              rdy_seen_o
);
  localparam int CNT_W = $clog2(RPT + 1);
  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(RPT);

  function automatic logic [CNT_W-1:0] run_advance(input logic [CNT_W-1:0] run,
                                                   input logic same);
    if (!same) return CNT_W'(1);
    if (run >= RUN_FULL) return RUN_FULL;
    return run + CNT_W'(1);
  endfunction

  logic [CODE_W-1:0] prev_q, filt_q;
  logic              prev_vld_q;
  logic [CNT_W-1:0]  run_q;
  logic [HIST_W-1:0] hist_q;

  // named internal events
  logic              same_w, crit_w, accept_w;
  logic [CNT_W-1:0]  run_nx;
  logic [CODE_W-1:0] filt_nx;
  logic [HIST_W-1:0] hist_nx;

  always_comb begin
    same_w   = prev_vld_q && (raw_i == prev_q);
    run_nx   = run_advance(run_q, same_w);
    crit_w   = code_is_crit(raw_i);
    accept_w = !crit_w || (run_nx == RUN_FULL && !clr_i);
    if (!active_i)     filt_nx = CODE_READY;
    else if (accept_w) filt_nx = raw_i;
    else               filt_nx = filt_q;
    if (clr_i)         hist_nx = '0;
    else if (active_i) hist_nx = hist_q | code_crit_bits(filt_nx);
    else               hist_nx = hist_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= CODE_READY;
      prev_vld_q <= 1'b0;
      run_q      <= '0;
      filt_q     <= CODE_READY;
      hist_q     <= '0;
    end else begin
      prev_q  <= raw_i;
      filt_q  <= filt_nx;
      hist_q  <= hist_nx;
      if (!active_i || clr_i) begin
        run_q      <= '0;
        prev_vld_q <= 1'b0;
      end else begin
        run_q      <= run_nx;
        prev_vld_q <= 1'b1;
      end
    end
  end

  assign filt_o     = active_i ? filt_q : CODE_READY;
  assign onehot_o   = active_i ? code_onehot(filt_q) : '0;
  assign hist_o     = hist_q;
  assign rdy_seen_o = active_i && (raw_i == CODE_READY);

  AST_CRIT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_q != $past(filt_q)) && code_is_crit(filt_q)) |-> (run_q == RUN_FULL)); // R2

  AST_HIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hist_q) & ~hist_q) != '0) |-> $past(clr_i)); // R5

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (hist_q == '0 && run_q == '0)); // R6
endmodule

// File: rtl/tts_resync_hold.sv
module tts_resync_hold #(
  parameter int NCH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           resync_i,
  input  logic [NCH-1:0] active_i,
  input  logic [NCH-1:0] rdy_seen_i,
  output logic           hold_o
);
  logic           hold_q;
  logic [NCH-1:0] seen_q, seen_nx;
  logic           all_done_w;

  assign seen_nx    = seen_q | rdy_seen_i;
  assign all_done_w = &(seen_nx | ~active_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      seen_q <= '0;
    end else if (resync_i) begin
      hold_q <= 1'b1;
      seen_q <= '0;
    end else if (hold_q && all_done_w) begin
      hold_q <= 1'b0;
      seen_q <= '0;
    end else if (hold_q) begin
      seen_q <= seen_nx;
    end
  end

  assign hold_o = hold_q;

  AST_RESYNC_SETS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resync_i |=> hold_q); // R9

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> !$past(resync_i)); // R10
endmodule

// File: rtl/tts_state_merge.sv
module tts_state_merge
  import tts_filt_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic [NCH*OH_W-1:0] oh_flat_i,
  input  logic                hold_i,
  output logic [OH_W-1:0]     comb_o
);
  logic [OH_W-1:0] any_w;

  always_comb begin
    any_w = '0;
    for (int ch = 0; ch < NCH; ch++) any_w |= oh_flat_i[ch*OH_W +: OH_W];
    if (hold_i) any_w[OH_BUSY] = 1'b1;
    comb_o = prio_pick(any_w);
  end
endmodule

// File: rtl/tts_filter_top.sv
module tts_filter_top
  import tts_filt_pkg::*;
#(
  parameter int NCH = 12,
  parameter int RPT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*CODE_W-1:0] raw_code_i,
  input  logic [NCH-1:0]        chan_en_i,
  input  logic [NCH-1:0]        chan_ign_i,
  input  logic                  resync_i,
  input  logic                  clear_i,
  output logic [NCH*CODE_W-1:0] filt_code_o,
  output logic [NCH*OH_W-1:0]   state_oh_o,
  output logic [NCH*HIST_W-1:0] hist_o,
  output logic [OH_W-1:0]       comb_oh_o
);
  logic [NCH-1:0] active_w;
  logic [NCH-1:0] rdy_seen_w;
  logic           hold_w;

  assign active_w = chan_en_i & ~chan_ign_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    tts_chan_filter #(.RPT(RPT)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_i      (raw_code_i[ch*CODE_W +: CODE_W]),
      .active_i   (active_w[ch]),
      .clr_i      (clear_i),
      .filt_o     (filt_code_o[ch*CODE_W +: CODE_W]),
      .onehot_o   (state_oh_o[ch*OH_W +: OH_W]),
      .hist_o     (hist_o[ch*HIST_W +: HIST_W]),
      .rdy_seen_o (rdy_seen_w[ch])
    );
  end

  tts_resync_hold #(.NCH(NCH)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .resync_i   (resync_i),
    .active_i   (active_w),
    .rdy_seen_i (rdy_seen_w),
    .hold_o     (hold_w)
  );

  tts_state_merge #(.NCH(NCH)) u_merge (
    .oh_flat_i (state_oh_o),
    .hold_i    (hold_w),
    .comb_o    (comb_oh_o)
  );

  AST_COMB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comb_oh_o)); // R8

  AST_HOLD_FORCES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_w && comb_oh_o[OH_W-1:OH_OOS] == '0) |-> comb_oh_o[OH_BUSY]); // R9
endmodule

// File: tb/tts_filter_top_test.sv
module tts_filter_top_test;
  localparam int CLK_P = 10;
  localparam int NCH   = 12;
  localparam int RPT   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*4-1:0]  raw = '0;
  logic [NCH-1:0]    en = '0, ign = '0;
  logic              resync = 1'b0, clr = 1'b0;
  logic [NCH*4-1:0]  filt;
  logic [NCH*5-1:0]  oh;
  logic [NCH*3-1:0]  hist;
  logic [4:0]        comb;

  int n_chk = 0, n_fail = 0;

  // bench model state
  logic [3:0] m_filt [NCH];
  logic [3:0] m_prev [NCH];
  logic       m_pv   [NCH];
  int         m_run  [NCH];
  logic [2:0] m_hist [NCH];
  logic       m_hold;
  logic [NCH-1:0] m_seen;

  always #(CLK_P/2) clk = ~clk;

  tts_filter_top #(.NCH(NCH), .RPT(RPT)) uut (
    .clk(clk), .rst_n(rst_n), .raw_code_i(raw), .chan_en_i(en), .chan_ign_i(ign),
    .resync_i(resync), .clear_i(clr), .filt_code_o(filt), .state_oh_o(oh),
    .hist_o(hist), .comb_oh_o(comb));

  function automatic logic [4:0] exp_oh(input logic [3:0] c);
    case (c)
      4'h8: return 5'b00000;
      4'h4: return 5'b00010;
      4'h1: return 5'b00001;
      4'h2: return 5'b00100;
      4'h0, 4'hF: return 5'b10000;
      default: return 5'b01000;
    endcase
  endfunction

  function automatic logic is_crit(input logic [3:0] c);
    logic [4:0] v;
    v = exp_oh(c);
    return v[4] | v[3] | v[2];
  endfunction

  function automatic logic [4:0] top_bit(input logic [4:0] v);
    if (v[4]) return 5'b10000;
    if (v[3]) return 5'b01000;
    if (v[2]) return 5'b00100;
    if (v[1]) return 5'b00010;
    if (v[0]) return 5'b00001;
    return 5'b00000;
  endfunction

  function automatic logic [3:0] pick_code(input int k);
    case (k)
      0: return 4'h8; 1: return 4'h4; 2: return 4'h1; 3: return 4'h2;
      4: return 4'hC; 5: return 4'h0; 6: return 4'hF; 7: return 4'h3;
      default: return 4'h8;
    endcase
  endfunction

  function automatic logic act(input int ch);
    return en[ch] & ~ign[ch];
  endfunction

  task automatic chk(input string tag, input int a, input int e);
    n_chk++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, a, e, $time);
    end
  endtask

  task automatic model_reset();
    for (int ch = 0; ch < NCH; ch++) begin
      m_filt[ch] = 4'h8; m_prev[ch] = 4'h8; m_pv[ch] = 1'b0;
      m_run[ch] = 0; m_hist[ch] = 3'b000;
    end
    m_hold = 1'b0; m_seen = '0;
  endtask

  task automatic model_step();
    logic [NCH-1:0] sn;
    logic done;
    for (int ch = 0; ch < NCH; ch++) begin
      logic [3:0] c;
      int rn;
      c = raw[ch*4 +: 4];
      if (!act(ch)) begin
        m_filt[ch] = 4'h8; m_run[ch] = 0; m_pv[ch] = 1'b0;
        if (clr) m_hist[ch] = 3'b000;
      end else begin
        rn = (m_pv[ch] && c == m_prev[ch]) ? ((m_run[ch] >= RPT) ? RPT : m_run[ch] + 1) : 1;
        if (!is_crit(c) || (rn >= RPT && !clr)) m_filt[ch] = c;
        m_run[ch] = clr ? 0 : rn;
        m_pv[ch]  = !clr;
        if (clr) m_hist[ch] = 3'b000;
        else m_hist[ch] = m_hist[ch] | exp_oh(m_filt[ch])[4:2];
      end
      m_prev[ch] = c;
    end
    if (resync) begin
      m_hold = 1'b1; m_seen = '0;
    end else if (m_hold) begin
      done = 1'b1;
      for (int ch = 0; ch < NCH; ch++) begin
        sn[ch] = m_seen[ch] | (act(ch) && raw[ch*4 +: 4] == 4'h8);
        if (act(ch) && !sn[ch]) done = 1'b0;
      end
      if (done) begin m_hold = 1'b0; m_seen = '0; end
      else m_seen = sn;
    end
  endtask

  function automatic logic [4:0] exp_comb();
    logic [4:0] v;
    v = '0;
    for (int ch = 0; ch < NCH; ch++) if (act(ch)) v |= exp_oh(m_filt[ch]);
    if (m_hold) v[1] = 1'b1;
    return top_bit(v);
  endfunction

  task automatic check_all();
    for (int ch = 0; ch < NCH; ch++) begin
      chk("R1/R2/R7 filt_code", filt[ch*4 +: 4], act(ch) ? m_filt[ch] : 4'h8);
      chk("R4/R7 state_oh", oh[ch*5 +: 5], act(ch) ? exp_oh(m_filt[ch]) : 5'b0);
      chk("R5/R6 hist", hist[ch*3 +: 3], m_hist[ch]);
    end
    chk("R8/R9/R10 comb", comb, exp_comb());
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic set_code(input int ch, input logic [3:0] c);
    raw[ch*4 +: 4] = c;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int ch = 0; ch < NCH; ch++) set_code(ch, 4'h8);
    en = '1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("reset filt", filt, {NCH{4'h8}});
    chk("reset hist", hist, 0);
    chk("reset comb", comb, 0);
    cycle();

    // R2: out-of-sync needs four identical samples
    set_code(0, 4'h2);
    repeat (3) cycle();
    chk("R2 held before 4th", filt[3:0], 4'h8);
    cycle();
    chk("R2 accepted on 4th", filt[3:0], 4'h2);
    chk("R4 oos one-hot", oh[4:0], 5'b00100);
    chk("R5 oos flag", hist[2:0], 3'b001);
    // R1: ready taken at once, flag stays
    set_code(0, 4'h8);
    cycle();
    chk("R1 ready immediate", filt[3:0], 4'h8);
    chk("R5 flag sticky", hist[2:0], 3'b001);
    set_code(0, 4'h1);
    cycle();
    chk("R1 ofw immediate", filt[3:0], 4'h1);
    chk("R8 comb ofw", comb, 5'b00001);
    set_code(0, 4'h8);
    cycle();

    // R3: broken run restarts count
    set_code(1, 4'hC); repeat (3) cycle();
    set_code(1, 4'h2); cycle();
    set_code(1, 4'hC); repeat (3) cycle();
    chk("R3 run restarted", filt[7:4], 4'h8);
    cycle();
    chk("R3 accepted after fresh run", filt[7:4], 4'hC);
    chk("R5 err flag", hist[5:3], 3'b010);
    chk("R8 comb error", comb, 5'b01000);
    set_code(1, 4'h8); cycle();

    // R6: clear wipes flags and run counts
    set_code(2, 4'h0); repeat (2) cycle();
    clr = 1'b1; cycle(); clr = 1'b0;
    chk("R6 flags cleared", hist, 0);
    repeat (3) cycle();
    chk("R6 run restarted after clear", filt[11:8], 4'h8);
    cycle();
    chk("R6 disconnect after clear", filt[11:8], 4'h0);
    chk("R8 comb disconnect", comb, 5'b10000);

    // R7: ignore takes effect in the same cycle
    ign[2] = 1'b1; #1;
    chk("R7 ignored reads ready", filt[11:8], 4'h8);
    chk("R7 ignored one-hot zero", oh[14:10], 5'b0);
    chk("R7 comb unaffected", comb, 5'b0);
    cycle();
    chk("R7 flags frozen", hist[8:6], 3'b100);
    set_code(2, 4'h8); ign[2] = 1'b0; cycle();

    // R9/R10: resync hold
    resync = 1'b1; set_code(3, 4'h1); cycle(); resync = 1'b0;
    chk("R9 busy beats ofw", comb, 5'b00010);
    cycle();
    chk("R10 hold kept without ready", comb, 5'b00010);
    set_code(3, 4'h8); cycle();
    chk("R10 hold released", comb, 5'b00000);
    set_code(4, 4'hF); repeat (4) cycle();
    resync = 1'b1; cycle(); resync = 1'b0;
    chk("R9 disconnect beats forced busy", comb, 5'b10000);
    set_code(4, 4'h8); cycle();
    chk("R10 release with all ready", comb, 5'b00000);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      for (int ch = 0; ch < NCH; ch++)
        if ($urandom % 5 == 0) set_code(ch, pick_code($urandom % 9));
      if ($urandom % 64 == 0) en[$urandom % NCH] ^= 1'b1;
      if ($urandom % 64 == 0) ign[$urandom % NCH] ^= 1'b1;
      resync = ($urandom % 40 == 0);
      clr    = ($urandom % 50 == 0);
      cycle();
    end
    resync = 1'b0; clr = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule